// File: doc/BRIEF.md
# Byte-Wide Asynchronous FIFO Port, Device Side

This block is the device end of a byte-wide parallel port driven by an external master through two asynchronous strobes. Pulling the write strobe from high to low stores the byte on `bus_in` into a transmit buffer. Holding `rd_stb_n` low drives the oldest received byte onto `bus_out`, with `bus_oe` marking that the pins are driven. Releasing the strobe retires that byte. Two active-low status flags tell the master when it may act. `accept_n` is low when a write will be taken. `avail_n` is low when at least one received byte is waiting. Both flags, and the data pins, are released (`stat_oe`, `bus_oe` low) while reset is asserted.

On the host side, the received data arrives on a valid/ready stream (`rx_*`). Transmit data leaves on a second valid/ready stream (`tx_*`) in bursts. A burst is released once `PKT_BYTES` bytes are waiting, or once the buffer has been non-empty and untouched for a latency time set in milliseconds on `lat_ms`. A millisecond prescaler divides the clock by `CLK_HZ/1000`.

There are three small state machines, and each has two states:
- The write machine moves from `W_IDLE` to `W_STORE` on an accepted strobe. It returns to `W_IDLE` after `STORE_CYC` cycles.
- The flush machine moves from `F_WAIT` to `F_DRAIN` on a fill trigger or a timeout trigger. It returns to `F_WAIT` when the final byte of the burst is taken.
- The read machine moves from `R_IDLE` to `R_DRIVE` when the read strobe falls and a byte is present. It returns to `R_IDLE` when the strobe rises, which pops the byte.

The strobes pass through a two-flop synchronizer followed by an edge register. Buffer depths must be powers of two.

Top module: `byteport_dev`

## Requirements
- R1: While `rst_n` is low, `stat_oe`, `bus_oe`, `tx_valid` and `overflow` are 0. One cycle after reset is released, `stat_oe` is 1, `accept_n` is 0 and `avail_n` is 1.
- R2: A falling edge on `wr_stb` while `accept_n` is low stores `bus_in`. The stored bytes appear on `tx_data` in the order they were written.
- R3: `accept_n` is high during `STORE_CYC` cycles, starting 3 cycles after the write strobe falls. It is also high whenever the transmit buffer holds `TX_DEPTH` bytes. Otherwise it is low.
- R4: A falling edge on `wr_stb` while `accept_n` is high stores nothing. It sets `overflow`, which stays 1 until reset.
- R5: When the transmit buffer reaches `PKT_BYTES` bytes, a burst of exactly `PKT_BYTES` bytes begins. Its final byte carries `tx_last`=1 and no other byte does. With no burst in progress, `tx_valid` rises 4 cycles after the falling strobe that filled the packet.
- R6: A non-empty buffer below `PKT_BYTES` bytes is released as a single burst of all its bytes. `tx_valid` rises L*P+4 cycles (within ±2) after the last write strobe falls, where L is the latency in ms and P is `CLK_HZ/1000`.
- R7: `lat_ms` = 0 selects a latency of 16 ms. Values 1 to 255 select that many ms.
- R8: Each accepted write restarts the latency timer. No timed burst starts earlier than L*P cycles after the most recent write.
- R9: `avail_n` is low exactly when the receive buffer holds a byte. `rx_ready` is low exactly when the receive buffer holds `RX_DEPTH` bytes.
- R10: With a byte present, `bus_oe` is 1 and `bus_out` holds the oldest byte from the third cycle after `rd_stb_n` falls. A rising edge of `rd_stb_n` retires that byte and clears `bus_oe`. A low strobe on an empty buffer drives nothing and retires nothing.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe from the master; the byte is taken on its falling edge |
| rd_stb_n | input | 1 | Active-low read strobe from the master |
| bus_in | input | 8 | Byte written by the master |
| bus_out | output | 8 | Byte presented to the master while `bus_oe` is 1 |
| bus_oe | output | 1 | Data pins driven |
| accept_n | output | 1 | Low when a write will be accepted |
| avail_n | output | 1 | Low when a received byte is waiting |
| stat_oe | output | 1 | Status flags driven (0 during reset) |
| lat_ms | input | 8 | Flush latency in ms; 0 selects 16 |
| overflow | output | 1 | Sticky: a write was ignored |
| tx_valid | output | 1 | Host transmit stream valid |
| tx_ready | input | 1 | Host transmit stream ready |
| tx_data | output | 8 | Host transmit stream byte |
| tx_last | output | 1 | Final byte of a burst |
| rx_valid | input | 1 | Host receive stream valid |
| rx_ready | output | 1 | Receive buffer has room |
| rx_data | input | 8 | Host receive stream byte |

## Verification
Counting from the cycle in which the bench changes a strobe, an edge becomes visible to the state machines two cycles later, and the machines act on the third. So `accept_n` is sampled low at offset 2, high at offsets 3 and 4, and low again at offset 5. The first `tx_valid` of a fill burst is expected at offset 4. Read data is sampled five cycles after the strobe change, which is safely inside the driven interval. Timed bursts are swept across latencies of 1 to 6 ms and the 16 ms default, with one to three bytes per burst. The bench times each burst from the cycle of the last write and compares the measured delay with L*P+4 computed arithmetically. All samples are taken on the falling clock edge, between the bench's input changes.

// File: rtl/byteport_pkg.sv
package byteport_pkg;
    typedef enum logic {W_IDLE, W_STORE} wr_state_e;
    typedef enum logic {F_WAIT, F_DRAIN} fl_state_e;
    typedef enum logic {R_IDLE, R_DRIVE} rd_state_e;
    localparam int unsigned DEFAULT_LAT_MS = 16;
endpackage

// File: rtl/byteport_sync.sv
module byteport_sync #(
    parameter int unsigned      WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] now,
    output logic [WIDTH-1:0] was
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            now  <= RST_VAL;
            was  <= RST_VAL;
        end else begin
            meta <= async_in;
            now  <= meta;
            was  <= now;
        end
    end
endmodule

// File: rtl/byteport_fifo.sv
module byteport_fifo #(
    parameter  int unsigned WIDTH = 8,
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rptr];
endmodule

// File: rtl/byteport_tx_ctrl.sv
module byteport_tx_ctrl
    import byteport_pkg::*;
#(
    parameter  int unsigned DEPTH     = 128,
    parameter  int unsigned PKT_BYTES = 64,
    parameter  int unsigned STORE_CYC = 4,
    parameter  int unsigned MS_CYC    = 48000,
    localparam int unsigned CW        = $clog2(DEPTH) + 1,
    localparam int unsigned SCW       = (STORE_CYC > 1) ? $clog2(STORE_CYC) : 1,
    localparam int unsigned PW        = (MS_CYC > 1) ? $clog2(MS_CYC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_now,
    input  logic          wr_was,
    input  logic [7:0]    lat_ms,
    input  logic [CW-1:0] count,
    input  logic          tx_ready,
    output logic          push,
    output logic          pop,
    output logic          busy,
    output logic          full,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          overflow
);
    localparam logic [CW-1:0] PKT_C  = CW'(PKT_BYTES);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    wr_state_e      wst, wst_nx;
    fl_state_e      fst, fst_nx;
    logic [SCW-1:0] scnt, scnt_nx;
    logic [CW-1:0]  burst, burst_nx;
    logic [PW-1:0]  presc;
    logic [7:0]     ms_cnt, lat_eff;
    logic           wr_fall, empty, fill_hit, time_hit;

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wst   <= W_IDLE;
            fst   <= F_WAIT;
            scnt  <= '0;
            burst <= '0;
        end else begin
            wst   <= wst_nx;
            fst   <= fst_nx;
            scnt  <= scnt_nx;
            burst <= burst_nx;
        end
    end

    // Next state
    always_comb begin
        wst_nx   = wst;
        scnt_nx  = scnt;
        fst_nx   = fst;
        burst_nx = burst;
        unique case (wst)
            W_IDLE: if (push) begin
                wst_nx  = W_STORE;
                scnt_nx = SCW'(STORE_CYC - 1);
            end
            W_STORE: if (scnt == '0) wst_nx = W_IDLE;
                     else scnt_nx = scnt - 1'b1;
        endcase
        unique case (fst)
            F_WAIT: if (fill_hit || time_hit) begin
                fst_nx   = F_DRAIN;
                burst_nx = fill_hit ? PKT_C : count;
            end
            F_DRAIN: if (tx_ready) begin
                burst_nx = burst - 1'b1;
                if (burst == CW'(1)) fst_nx = F_WAIT;
            end
        endcase
    end

    // Outputs
    always_comb begin
        wr_fall  = wr_was && !wr_now;
        full     = (count == FULL_C);
        empty    = (count == '0);
        busy     = (wst == W_STORE);
        push     = (wst == W_IDLE) && wr_fall && !full;
        lat_eff  = (lat_ms == 8'd0) ? 8'(DEFAULT_LAT_MS) : lat_ms;
        fill_hit = (count >= PKT_C);
        time_hit = !empty && (ms_cnt >= lat_eff);
        tx_valid = (fst == F_DRAIN);
        tx_last  = (fst == F_DRAIN) && (burst == CW'(1));
        pop      = (fst == F_DRAIN) && tx_ready;
    end

    // Latency timer: restarted by writes, idle while empty or draining
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc  <= '0;
            ms_cnt <= '0;
        end else if (push || fst != F_WAIT || empty) begin
            presc  <= '0;
            ms_cnt <= '0;
        end else if (presc == PW'(MS_CYC - 1)) begin
            presc  <= '0;
            ms_cnt <= (ms_cnt == 8'hFF) ? ms_cnt : ms_cnt + 8'd1;
        end else begin
            presc  <= presc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       overflow <= 1'b0;
        else if (wr_fall && (busy || full)) overflow <= 1'b1;
    end
endmodule

// File: rtl/byteport_rx_ctrl.sv
module byteport_rx_ctrl
    import byteport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_now,
    input  logic rd_was,
    input  logic empty,
    output logic pop,
    output logic drive
);
    rd_state_e rst_q, rst_nx;
    logic      rd_fall, rd_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= R_IDLE;
        else        rst_q <= rst_nx;
    end

    always_comb begin
        rst_nx = rst_q;
        unique case (rst_q)
            R_IDLE:  if (rd_fall && !empty) rst_nx = R_DRIVE;
            R_DRIVE: if (rd_rise)           rst_nx = R_IDLE;
        endcase
    end

    always_comb begin
        rd_fall = rd_was && !rd_now;
        rd_rise = !rd_was && rd_now;
        drive   = (rst_q == R_DRIVE);
        pop     = (rst_q == R_DRIVE) && rd_rise;
    end
endmodule

// File: rtl/byteport_dev.sv
module byteport_dev
    import byteport_pkg::*;
#(
    parameter  int unsigned CLK_HZ    = 48_000_000,
    parameter  int unsigned TX_DEPTH  = 128,
    parameter  int unsigned RX_DEPTH  = 256,
    parameter  int unsigned PKT_BYTES = 64,
    parameter  int unsigned STORE_CYC = 4,
    localparam int unsigned MS_CYC    = CLK_HZ / 1000,
    localparam int unsigned TX_CW     = $clog2(TX_DEPTH) + 1,
    localparam int unsigned RX_CW     = $clog2(RX_DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       rd_stb_n,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       accept_n,
    output logic       avail_n,
    output logic       stat_oe,
    input  logic [7:0] lat_ms,
    output logic       overflow,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    output logic       tx_last,
    input  logic       rx_valid,
    output logic       rx_ready,
    input  logic [7:0] rx_data
);
    logic [1:0]       s_now, s_was;
    logic [TX_CW-1:0] tx_count;
    logic [RX_CW-1:0] rx_count;
    logic             tx_push, tx_pop, tx_busy, tx_full;
    logic             rx_pop, rx_push, rx_empty, rd_drive;
    logic [7:0]       rx_head;

    // bit 1: read strobe (idles high), bit 0: write strobe (idles low)
    byteport_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({rd_stb_n, wr_stb}),
        .now(s_now), .was(s_was)
    );

    byteport_tx_ctrl #(
        .DEPTH(TX_DEPTH), .PKT_BYTES(PKT_BYTES),
        .STORE_CYC(STORE_CYC), .MS_CYC(MS_CYC)
    ) u_txc (
        .clk(clk), .rst_n(rst_n), .wr_now(s_now[0]), .wr_was(s_was[0]),
        .lat_ms(lat_ms), .count(tx_count), .tx_ready(tx_ready),
        .push(tx_push), .pop(tx_pop), .busy(tx_busy), .full(tx_full),
        .tx_valid(tx_valid), .tx_last(tx_last), .overflow(overflow)
    );

    byteport_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txbuf (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_in),
        .pop(tx_pop), .rdata(tx_data), .count(tx_count)
    );

    byteport_rx_ctrl u_rxc (
        .clk(clk), .rst_n(rst_n), .rd_now(s_now[1]), .rd_was(s_was[1]),
        .empty(rx_empty), .pop(rx_pop), .drive(rd_drive)
    );

    byteport_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_data),
        .pop(rx_pop), .rdata(rx_head), .count(rx_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_oe <= 1'b0;
        else        stat_oe <= 1'b1;
    end

    always_comb begin
        rx_empty = (rx_count == '0);
        rx_ready = (rx_count != RX_CW'(RX_DEPTH));
        rx_push  = rx_valid && rx_ready;
        accept_n = tx_full || tx_busy;
        avail_n  = rx_empty;
        bus_oe   = rd_drive;
        bus_out  = rd_drive ? rx_head : 8'h00;
    end
endmodule

// File: rtl/byteport_dev_chk.sv
module byteport_dev_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_oe,
    input logic       bus_oe,
    input logic       avail_n,
    input logic       accept_n,
    input logic       overflow,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_last
);
    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            released_in_reset_chk: assert (!stat_oe && !bus_oe && !tx_valid && !overflow);
        end
    end

    // R1
    stat_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stat_oe);

    // R4
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R4
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(accept_n));

    // R10
    drive_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !avail_n);

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R5
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
endmodule

bind byteport_dev byteport_dev_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stat_oe(stat_oe), .bus_oe(bus_oe),
    .avail_n(avail_n), .accept_n(accept_n), .overflow(overflow),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
);

// File: tb/byteport_dev_bench.sv
`timescale 1ns/1ps
module byteport_dev_bench;
    localparam int CLK_HZ = 4000;
    localparam int P      = CLK_HZ / 1000;
    localparam int TXD    = 8;
    localparam int RXD    = 4;
    localparam int PKT    = 4;
    localparam int STC    = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0, wr_stb = 1'b0, rd_stb_n = 1'b1;
    logic [7:0] bus_in = '0, lat_ms = 8'd1, rx_data = '0;
    logic       tx_ready = 1'b1, rx_valid = 1'b0;
    logic [7:0] bus_out, tx_data;
    logic       bus_oe, accept_n, avail_n, stat_oe, overflow, tx_valid, tx_last, rx_ready;

    byteport_dev #(.CLK_HZ(CLK_HZ), .TX_DEPTH(TXD), .RX_DEPTH(RXD),
                   .PKT_BYTES(PKT), .STORE_CYC(STC)) u_byteport_dev (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb_n(rd_stb_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .accept_n(accept_n), .avail_n(avail_n), .stat_oe(stat_oe),
        .lat_ms(lat_ms), .overflow(overflow), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nbad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Host transmit monitor (sampled on the falling edge)
    logic [7:0] got_d [256];
    bit         got_l [256];
    int         gcnt = 0, fv_cyc = -1;
    bit         prev_v = 1'b0;
    always @(negedge clk) begin
        if (tx_valid && !prev_v) fv_cyc = cyc;
        prev_v = tx_valid;
        if (tx_valid && tx_ready && gcnt < 256) begin
            got_d[gcnt] = tx_data;
            got_l[gcnt] = tx_last;
            gcnt++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input logic [7:0] d, output int fall_at);
        bus_in = d;
        wr_stb = 1'b1;
        repeat (3) tick();
        wr_stb = 1'b0;
        fall_at = cyc;
        repeat (6) tick();
    endtask

    task automatic wr_byte(input logic [7:0] d, output int fall_at);
        int k = 0;
        while (accept_n && k < 500) begin tick(); k++; end
        strobe(d, fall_at);
    endtask

    task automatic wait_bytes(input int n, input int lim);
        int k = 0;
        while (gcnt < n && k < lim) begin tick(); k++; end
    endtask

    task automatic rx_push(input logic [7:0] d, input bit exp_rdy);
        rx_data  = d;
        rx_valid = 1'b1;
        @(negedge clk);
        chk(rx_ready == exp_rdy, "R9 rx_ready", rx_ready, exp_rdy);
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic rd_byte(input bit exp_oe, input logic [7:0] d);
        rd_stb_n = 1'b0;
        repeat (5) tick();
        @(negedge clk);
        chk(bus_oe == exp_oe, "R10 bus_oe while low", bus_oe, exp_oe);
        if (exp_oe) chk(bus_out == d, "R10 bus_out", bus_out, d);
        tick();
        rd_stb_n = 1'b1;
        repeat (5) tick();
        @(negedge clk);
        chk(bus_oe == 1'b0, "R10 bus_oe after rise", bus_oe, 0);
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            nchk++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int fa, base, delta;
        logic [7:0] exp_b [16];

        // ---- R1 reset
        repeat (4) tick();
        @(negedge clk);
        chk(stat_oe == 0,  "R1 stat_oe in reset", stat_oe, 0);
        chk(bus_oe == 0,   "R1 bus_oe in reset", bus_oe, 0);
        chk(tx_valid == 0, "R1 tx_valid in reset", tx_valid, 0);
        chk(overflow == 0, "R1 overflow in reset", overflow, 0);
        tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk(stat_oe == 1,  "R1 stat_oe after reset", stat_oe, 1);
        chk(accept_n == 0, "R1 accept_n after reset", accept_n, 0);
        chk(avail_n == 1,  "R1 avail_n after reset", avail_n, 1);
        tick();

        // ---- R3 store-busy window, exact cycles
        lat_ms = 8'd255;
        bus_in = 8'h5A;
        wr_stb = 1'b1;
        repeat (3) tick();
        wr_stb = 1'b0;
        fa = cyc;
        repeat (3) @(negedge clk);
        chk(accept_n == 0, "R3 accept_n at +2", accept_n, 0);
        @(negedge clk);
        chk(accept_n == 1, "R3 accept_n at +3", accept_n, 1);
        @(negedge clk);
        chk(accept_n == 1, "R3 accept_n at +4", accept_n, 1);
        @(negedge clk);
        chk(accept_n == 0, "R3 accept_n at +5", accept_n, 0);
        tick();
        base = gcnt;
        lat_ms = 8'd1;
        wait_bytes(base + 1, 100);
        chk(gcnt == base + 1, "R6 single byte flushed", gcnt - base, 1);
        chk(got_d[base] == 8'h5A, "R2 stored value", got_d[base], 8'h5A);
        chk(got_l[base] == 1, "R6 last on single", got_l[base], 1);
        repeat (4) tick();

        // ---- R6 / R8 timed flush sweep over latency and byte count
        for (int L = 1; L <= 6; L++) begin
            for (int n = 1; n <= ((L >= 4) ? 3 : 1); n++) begin
                lat_ms = 8'(L);
                base = gcnt;
                fv_cyc = -1;
                for (int i = 0; i < n; i++) begin
                    exp_b[i] = 8'(L * 16 + n * 4 + i);
                    wr_byte(exp_b[i], fa);
                end
                wait_bytes(base + n, 400);
                chk(gcnt == base + n, "R6 burst size", gcnt - base, n);
                delta = fv_cyc - fa;
                if (n > 1)
                    chk(delta >= L * P + 2 && delta <= L * P + 6, "R8 latency from last write", delta, L * P + 4);
                else
                    chk(delta >= L * P + 2 && delta <= L * P + 6, "R6 latency", delta, L * P + 4);
                for (int i = 0; i < n; i++) begin
                    chk(got_d[base + i] == exp_b[i], "R2 order", got_d[base + i], exp_b[i]);
                    chk(got_l[base + i] == (i == n - 1), "R6 last flag", got_l[base + i], (i == n - 1));
                end
                repeat (3) tick();
            end
        end

        // ---- R7 default latency
        lat_ms = 8'd0;
        base = gcnt;
        fv_cyc = -1;
        wr_byte(8'hC3, fa);
        wait_bytes(base + 1, 400);
        delta = fv_cyc - fa;
        chk(delta >= 16 * P + 2 && delta <= 16 * P + 6, "R7 default 16 ms", delta, 16 * P + 4);
        chk(got_d[base] == 8'hC3, "R7 data", got_d[base], 8'hC3);
        repeat (3) tick();

        // ---- R5 fill flush
        lat_ms = 8'd255;
        base = gcnt;
        fv_cyc = -1;
        for (int i = 0; i < PKT; i++) wr_byte(8'(8'hA0 + i), fa);
        wait_bytes(base + PKT, 50);
        chk(fv_cyc - fa == 4, "R5 fill latency", fv_cyc - fa, 4);
        for (int i = 0; i < PKT; i++) begin
            chk(got_d[base + i] == 8'(8'hA0 + i), "R5 data", got_d[base + i], 8'hA0 + i);
            chk(got_l[base + i] == (i == PKT - 1), "R5 last flag", got_l[base + i], (i == PKT - 1));
        end
        repeat (3) tick();

        // ---- R11, R3 full, R4 overflow with a stalled host
        tx_ready = 1'b0;
        base = gcnt;
        for (int i = 0; i < TXD; i++) begin
            wr_byte(8'(8'hB0 + i), fa);
            if (i == 5 || i == 7) begin
                @(negedge clk);
                chk(tx_valid == 1, "R11 valid held", tx_valid, 1);
                chk(tx_data == 8'hB0, "R11 data held", tx_data, 8'hB0);
                chk(tx_last == 0, "R11 last held", tx_last, 0);
            end
        end
        @(negedge clk);
        chk(accept_n == 1, "R3 accept_n when full", accept_n, 1);
        chk(overflow == 0, "R4 overflow before", overflow, 0);
        tick();
        strobe(8'hEE, fa);
        @(negedge clk);
        chk(overflow == 1, "R4 overflow set", overflow, 1);
        tick();
        tx_ready = 1'b1;
        wait_bytes(base + TXD, 100);
        repeat (20) tick();
        chk(gcnt == base + TXD, "R4 ignored byte absent", gcnt - base, TXD);
        for (int i = 0; i < TXD; i++) begin
            chk(got_d[base + i] == 8'(8'hB0 + i), "R2 order after stall", got_d[base + i], 8'hB0 + i);
            chk(got_l[base + i] == (i % PKT == PKT - 1), "R5 burst boundary", got_l[base + i], (i % PKT == PKT - 1));
        end
        @(negedge clk);
        chk(overflow == 1, "R4 overflow sticky", overflow, 1);
        chk(accept_n == 0, "R3 accept_n after drain", accept_n, 0);
        tick();

        // ---- R9 / R10 receive side, every fill level
        for (int k = 1; k <= RXD; k++) begin
            for (int i = 0; i < k; i++) rx_push(8'(8'h40 + 16 * k + i), 1'b1);
            @(negedge clk);
            chk(avail_n == 0, "R9 avail_n with data", avail_n, 0);
            chk(rx_ready == (k != RXD), "R9 rx_ready level", rx_ready, (k != RXD));
            tick();
            for (int i = 0; i < k; i++) begin
                rd_byte(1'b1, 8'(8'h40 + 16 * k + i));
                @(negedge clk);
                chk(avail_n == (i == k - 1), "R9 avail_n after read", avail_n, (i == k - 1));
                tick();
            end
        end
        rd_byte(1'b0, 8'h00);
        rx_push(8'h77, 1'b1);
        rd_byte(1'b1, 8'h77);
        @(negedge clk);
        chk(avail_n == 1, "R10 empty read retired nothing", avail_n, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule